// File: doc/BRIEF.md
# Pending-Coherence Forwarding Controller

This block sits in a second-level cache on the path taken by coherence messages from the directory. When it accepts a message for a line, it first sets that line's pending-coherence bit. It then passes the action up to the first-level cache and waits for the first-level cache's coherence reply. Only when that reply arrives does the block complete the action: it clears the bit and answers the directory. For a cache-to-cache transfer whose reply carries data, it also sends a data reply to the requesting node.

The pending bits form an array with one bit per set and way. A combinational lookup port lets the request path test any line, so that requests to a line under coherence can be stalled. The block runs one coherence transaction at a time. A second message is held off with backpressure until the first one has fully completed. That includes delivery of every response it produced. If either output port is busy, the response waits in a holding register. Line lookup and data array timing are handled elsewhere.

Top module: `cohfwd_ctrl`

## Requirements
- R1: On the clock edge where `coh_valid` and `coh_ready` are both high, the pending bit of line (`coh_set`, `coh_way`) becomes set. It reads 1 on `lk_pending` from the next cycle. `up_valid` rises in that same next cycle.
- R2: The upward message carries the accepted kind, set and way. Kind encodings are 0 invalidate, 1 downgrade, 2 write-back request and 3 cache-to-cache transfer. While `up_ready` is low, `up_valid` and the upward fields stay unchanged. No directory response is produced before an upper reply arrives.
- R3: When the upper reply completes a transaction, the line's pending bit is cleared. From the next cycle `lk_pending` reads 0 for that line.
- R4: Upper reply status uses these codes: 0 acknowledge, 1 acknowledge with data, 2 negative/still pending; code 3 is treated as 0. The directory code is derived from the status as follows. Status 0 gives code 0 (ack), with `dir_data` zero. Status 1 gives code 1 (copyback), with `dir_data` equal to `upr_data`. Status 2 gives code 2 (nack), with `dir_data` zero. In each case `dir_set`/`dir_way` name the line.
- R5: For kind 3 with status 1, a requester reply is produced in the same cycle as the directory copyback. It carries the `coh_node` given with the message and the reply data. For any other combination of kind and status, no requester reply is produced.
- R6: For kind 2, a status 2 reply is not forwarded. No directory response appears, the pending bit stays set, and the block waits for the next upper reply, which then completes the transaction under R3 to R5.
- R7: `coh_ready` is low from the cycle after an acceptance until every response produced has been taken by its port. It is also low whenever the addressed line is pending. It returns high one cycle after the last response is taken.
- R8: While `dir_ready` is low, `dir_valid` and all directory fields hold steady. While `req_ready` is low, `req_valid` and the requester fields hold steady. Each response is presented exactly once and drops on the edge where its ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coh_valid | input | 1 | Directory coherence message valid |
| coh_ready | output | 1 | Controller can accept a coherence message |
| coh_kind | input | 2 | Coherence kind (0 inval, 1 downgrade, 2 write-back, 3 transfer) |
| coh_set | input | SET_W | Set of the target line |
| coh_way | input | WAY_W | Way of the target line |
| coh_node | input | NODE_W | Node that asked for a transfer |
| up_valid | output | 1 | Upward coherence message valid |
| up_ready | input | 1 | Upper cache accepts the message |
| up_kind | output | 2 | Forwarded kind |
| up_set | output | SET_W | Forwarded set |
| up_way | output | WAY_W | Forwarded way |
| upr_valid | input | 1 | Upper cache coherence reply valid |
| upr_status | input | 2 | Reply status (0 ack, 1 ack with data, 2 nack) |
| upr_data | input | DATA_W | Reply data |
| dir_valid | output | 1 | Directory response valid |
| dir_ready | input | 1 | Directory port accepts the response |
| dir_code | output | 2 | Response code (0 ack, 1 copyback, 2 nack) |
| dir_set | output | SET_W | Set of the answered line |
| dir_way | output | WAY_W | Way of the answered line |
| dir_data | output | DATA_W | Copyback data |
| req_valid | output | 1 | Requester data reply valid |
| req_ready | input | 1 | Requester port accepts the reply |
| req_node | output | NODE_W | Destination node of the reply |
| req_data | output | DATA_W | Transferred data |
| lk_set | input | SET_W | Lookup set |
| lk_way | input | WAY_W | Lookup way |
| lk_pending | output | 1 | Pending bit of the looked-up line |

## Verification
The hardest situation to reach is the split drain of a transfer. The requester reply leaves at once while the directory copyback is stalled, and a fresh coherence message waits at the input. The bench reaches it by holding `dir_ready` low while it answers a transfer with data. It then raises the next message and checks that `coh_ready` stays low until the copyback is taken, and high one cycle later. The absorbed negative reply on a write-back request is also only visible as the absence of output, so the bench probes the line with the lookup port and then sends a second reply to end the transaction.

// File: rtl/cohfwd_pkg.sv
package cohfwd_pkg;

   localparam logic [1:0] KIND_INVAL = 2'd0;
   localparam logic [1:0] KIND_DOWN  = 2'd1;
   localparam logic [1:0] KIND_WRBK  = 2'd2;
   localparam logic [1:0] KIND_XFER  = 2'd3;

   localparam logic [1:0] UST_ACK  = 2'd0;
   localparam logic [1:0] UST_DATA = 2'd1;
   localparam logic [1:0] UST_NACK = 2'd2;

   localparam logic [1:0] DCODE_ACK  = 2'd0;
   localparam logic [1:0] DCODE_COPY = 2'd1;
   localparam logic [1:0] DCODE_NACK = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FWD  = 2'd1,
      ST_WAIT = 2'd2,
      ST_RESP = 2'd3
   } seq_state_e;

endpackage

// File: rtl/cohfwd_pend_bits.sv
module cohfwd_pend_bits #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int NRD   = 3,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [SET_W-1:0]     set_idx,
   input  logic [WAY_W-1:0]     set_way,
   input  logic                 clr_en,
   input  logic [SET_W-1:0]     clr_idx,
   input  logic [WAY_W-1:0]     clr_way,
   input  logic [NRD*SET_W-1:0] rd_set,
   input  logic [NRD*WAY_W-1:0] rd_way,
   output logic [NRD-1:0]       rd_bit
);

   logic [WAYS-1:0] bits [SETS];

   genvar gs;
   generate
      for (gs = 0; gs < SETS; gs++) begin : g_set
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bits[gs] <= '0;
            end else begin
               for (int w = 0; w < WAYS; w++) begin
                  if (set_en && (set_idx == SET_W'(gs)) && (set_way == WAY_W'(w)))
                     bits[gs][w] <= 1'b1;
                  else if (clr_en && (clr_idx == SET_W'(gs)) && (clr_way == WAY_W'(w)))
                     bits[gs][w] <= 1'b0;
               end
            end
         end
      end
   endgenerate

   genvar gr;
   generate
      for (gr = 0; gr < NRD; gr++) begin : g_rd
         assign rd_bit[gr] = bits[rd_set[gr*SET_W +: SET_W]][rd_way[gr*WAY_W +: WAY_W]];
      end
   endgenerate

endmodule

// File: rtl/cohfwd_hold.sv
module cohfwd_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/cohfwd_seq.sv
module cohfwd_seq
   import cohfwd_pkg::*;
#(
   parameter int SET_W  = 4,
   parameter int WAY_W  = 2,
   parameter int NODE_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coh_fire,
   input  logic [1:0]        coh_kind,
   input  logic [SET_W-1:0]  coh_set,
   input  logic [WAY_W-1:0]  coh_way,
   input  logic [NODE_W-1:0] coh_node,
   input  logic              up_ready,
   input  logic              upr_valid,
   input  logic [1:0]        upr_status,
   input  logic [DATA_W-1:0] upr_data,
   input  logic              dir_busy,
   input  logic              req_busy,
   output logic              idle,
   output logic              up_valid,
   output logic [1:0]        cur_kind,
   output logic [SET_W-1:0]  cur_set,
   output logic [WAY_W-1:0]  cur_way,
   output logic [NODE_W-1:0] cur_node,
   output logic              done,
   output logic [1:0]        done_code,
   output logic [DATA_W-1:0] done_data,
   output logic              done_req
);

   seq_state_e st, st_nx;
   logic       absorb;
   logic       got_reply;

   assign got_reply = (st == ST_WAIT) && upr_valid;
   assign absorb    = (cur_kind == KIND_WRBK) && (upr_status == UST_NACK);
   assign done      = got_reply && !absorb;
   assign done_req  = (cur_kind == KIND_XFER) && (upr_status == UST_DATA);
   assign done_data = (upr_status == UST_DATA) ? upr_data : '0;

   always_comb begin
      case (upr_status)
         UST_DATA: done_code = DCODE_COPY;
         UST_NACK: done_code = DCODE_NACK;
         default:  done_code = DCODE_ACK;
      endcase
   end

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE: if (coh_fire)              st_nx = ST_FWD;
         ST_FWD:  if (up_ready)              st_nx = ST_WAIT;
         ST_WAIT: if (done)                  st_nx = ST_RESP;
         ST_RESP: if (!dir_busy && !req_busy) st_nx = ST_IDLE;
         default:                            st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cur_kind <= '0;
         cur_set  <= '0;
         cur_way  <= '0;
         cur_node <= '0;
      end else begin
         st <= st_nx;
         if (coh_fire) begin
            cur_kind <= coh_kind;
            cur_set  <= coh_set;
            cur_way  <= coh_way;
            cur_node <= coh_node;
         end
      end
   end

   assign idle     = (st == ST_IDLE);
   assign up_valid = (st == ST_FWD);

endmodule

// File: rtl/cohfwd_ctrl.sv
module cohfwd_ctrl #(
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   parameter int NODE_W = 4,
   parameter int DATA_W = 32,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coh_valid,
   output logic              coh_ready,
   input  logic [1:0]        coh_kind,
   input  logic [SET_W-1:0]  coh_set,
   input  logic [WAY_W-1:0]  coh_way,
   input  logic [NODE_W-1:0] coh_node,
   output logic              up_valid,
   input  logic              up_ready,
   output logic [1:0]        up_kind,
   output logic [SET_W-1:0]  up_set,
   output logic [WAY_W-1:0]  up_way,
   input  logic              upr_valid,
   input  logic [1:0]        upr_status,
   input  logic [DATA_W-1:0] upr_data,
   output logic              dir_valid,
   input  logic              dir_ready,
   output logic [1:0]        dir_code,
   output logic [SET_W-1:0]  dir_set,
   output logic [WAY_W-1:0]  dir_way,
   output logic [DATA_W-1:0] dir_data,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [NODE_W-1:0] req_node,
   output logic [DATA_W-1:0] req_data,
   input  logic [SET_W-1:0]  lk_set,
   input  logic [WAY_W-1:0]  lk_way,
   output logic              lk_pending
);

   localparam int NRD    = 3;
   localparam int DIR_W  = 2 + SET_W + WAY_W + DATA_W;
   localparam int REQ_W  = NODE_W + DATA_W;

   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("cohfwd_ctrl: SETS must be a power of two of at least 2");
      end
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("cohfwd_ctrl: WAYS must be a power of two of at least 2");
      end
      if (NODE_W < 1 || DATA_W < 1) begin : g_bad_widths
         $error("cohfwd_ctrl: NODE_W and DATA_W must be positive");
      end
   endgenerate

   logic              idle;
   logic              coh_fire;
   logic [1:0]        cur_kind;
   logic [SET_W-1:0]  cur_set;
   logic [WAY_W-1:0]  cur_way;
   logic [NODE_W-1:0] cur_node;
   logic              done;
   logic [1:0]        done_code;
   logic [DATA_W-1:0] done_data;
   logic              done_req;
   logic [NRD-1:0]    pend_rd;
   logic              cur_pend;
   logic              in_pend;
   logic [DIR_W-1:0]  dir_word;
   logic [REQ_W-1:0]  req_word;

   assign in_pend   = pend_rd[1];
   assign cur_pend  = pend_rd[2];
   assign coh_ready = idle && !in_pend;
   assign coh_fire  = coh_valid && coh_ready;

   cohfwd_pend_bits #(
      .SETS (SETS),
      .WAYS (WAYS),
      .NRD  (NRD)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (coh_fire),
      .set_idx (coh_set),
      .set_way (coh_way),
      .clr_en  (done),
      .clr_idx (cur_set),
      .clr_way (cur_way),
      .rd_set  ({cur_set, coh_set, lk_set}),
      .rd_way  ({cur_way, coh_way, lk_way}),
      .rd_bit  (pend_rd)
   );

   assign lk_pending = pend_rd[0];

   cohfwd_seq #(
      .SET_W  (SET_W),
      .WAY_W  (WAY_W),
      .NODE_W (NODE_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .coh_fire   (coh_fire),
      .coh_kind   (coh_kind),
      .coh_set    (coh_set),
      .coh_way    (coh_way),
      .coh_node   (coh_node),
      .up_ready   (up_ready),
      .upr_valid  (upr_valid),
      .upr_status (upr_status),
      .upr_data   (upr_data),
      .dir_busy   (dir_valid),
      .req_busy   (req_valid),
      .idle       (idle),
      .up_valid   (up_valid),
      .cur_kind   (cur_kind),
      .cur_set    (cur_set),
      .cur_way    (cur_way),
      .cur_node   (cur_node),
      .done       (done),
      .done_code  (done_code),
      .done_data  (done_data),
      .done_req   (done_req)
   );

   assign up_kind = cur_kind;
   assign up_set  = cur_set;
   assign up_way  = cur_way;

   cohfwd_hold #(.W(DIR_W)) u_dir_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (done),
      .load_data ({done_code, cur_set, cur_way, done_data}),
      .ready     (dir_ready),
      .valid     (dir_valid),
      .data      (dir_word)
   );

   assign {dir_code, dir_set, dir_way, dir_data} = dir_word;

   cohfwd_hold #(.W(REQ_W)) u_req_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (done && done_req),
      .load_data ({cur_node, upr_data}),
      .ready     (req_ready),
      .valid     (req_valid),
      .data      (req_word)
   );

   assign {req_node, req_data} = req_word;

endmodule

// File: rtl/cohfwd_chk.sv
module cohfwd_chk #(
   parameter int SET_W  = 4,
   parameter int WAY_W  = 2,
   parameter int NODE_W = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coh_valid,
   input logic              coh_ready,
   input logic              up_valid,
   input logic              up_ready,
   input logic [1:0]        up_kind,
   input logic [SET_W-1:0]  up_set,
   input logic [WAY_W-1:0]  up_way,
   input logic              dir_valid,
   input logic              dir_ready,
   input logic [1:0]        dir_code,
   input logic [DATA_W-1:0] dir_data,
   input logic              req_valid,
   input logic              req_ready,
   input logic [NODE_W-1:0] req_node,
   input logic [DATA_W-1:0] req_data,
   input logic              cur_pend
);

   // R7
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coh_valid && coh_ready) |=> !coh_ready);

   // R1
   fwd_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coh_valid && coh_ready) |=> up_valid);

   // R1
   pend_while_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> cur_pend);

   // R2
   up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_ready) |=> (up_valid && $stable(up_kind) && $stable(up_set) && $stable(up_way)));

   // R8
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_code) && $stable(dir_data)));

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_node) && $stable(req_data)));

   // R5
   req_with_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $rose(dir_valid));

   // R3
   pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dir_valid) |-> !cur_pend);

endmodule

bind cohfwd_ctrl cohfwd_chk #(
   .SET_W  (SET_W),
   .WAY_W  (WAY_W),
   .NODE_W (NODE_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .coh_valid (coh_valid),
   .coh_ready (coh_ready),
   .up_valid  (up_valid),
   .up_ready  (up_ready),
   .up_kind   (up_kind),
   .up_set    (up_set),
   .up_way    (up_way),
   .dir_valid (dir_valid),
   .dir_ready (dir_ready),
   .dir_code  (dir_code),
   .dir_data  (dir_data),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_node  (req_node),
   .req_data  (req_data),
   .cur_pend  (cur_pend)
);

// File: tb/cohfwd_ctrl_test.sv
`timescale 1ns/1ps
module cohfwd_ctrl_test;

   localparam int SETS = 16, WAYS = 4, NODE_W = 4, DATA_W = 32;
   localparam int SET_W = $clog2(SETS), WAY_W = $clog2(WAYS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic coh_valid = 1'b0;
   logic coh_ready;
   logic [1:0] coh_kind = '0;
   logic [SET_W-1:0] coh_set = '0;
   logic [WAY_W-1:0] coh_way = '0;
   logic [NODE_W-1:0] coh_node = '0;
   logic up_valid;
   logic up_ready = 1'b1;
   logic [1:0] up_kind;
   logic [SET_W-1:0] up_set;
   logic [WAY_W-1:0] up_way;
   logic upr_valid = 1'b0;
   logic [1:0] upr_status = '0;
   logic [DATA_W-1:0] upr_data = '0;
   logic dir_valid;
   logic dir_ready = 1'b1;
   logic [1:0] dir_code;
   logic [SET_W-1:0] dir_set;
   logic [WAY_W-1:0] dir_way;
   logic [DATA_W-1:0] dir_data;
   logic req_valid;
   logic req_ready = 1'b1;
   logic [NODE_W-1:0] req_node;
   logic [DATA_W-1:0] req_data;
   logic [SET_W-1:0] lk_set = '0;
   logic [WAY_W-1:0] lk_way = '0;
   logic lk_pending;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cohfwd_ctrl #(.SETS(SETS), .WAYS(WAYS), .NODE_W(NODE_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .coh_valid(coh_valid), .coh_ready(coh_ready), .coh_kind(coh_kind),
      .coh_set(coh_set), .coh_way(coh_way), .coh_node(coh_node),
      .up_valid(up_valid), .up_ready(up_ready), .up_kind(up_kind),
      .up_set(up_set), .up_way(up_way),
      .upr_valid(upr_valid), .upr_status(upr_status), .upr_data(upr_data),
      .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_code(dir_code),
      .dir_set(dir_set), .dir_way(dir_way), .dir_data(dir_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
      .req_data(req_data),
      .lk_set(lk_set), .lk_way(lk_way), .lk_pending(lk_pending)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]        kind;
      logic [SET_W-1:0]  set;
      logic [WAY_W-1:0]  way;
      logic [NODE_W-1:0] node;
      logic [1:0]        stat;
      logic [DATA_W-1:0] data;
      logic [1:0]        dcode;
      logic              rq;
   } vec_t;

   localparam vec_t TBL [10] = '{
      '{2'd0, 4'd3,  2'd1, 4'd0, 2'd0, 32'h1111_0000, 2'd0, 1'b0},
      '{2'd0, 4'd5,  2'd2, 4'd1, 2'd2, 32'h2222_0000, 2'd2, 1'b0},
      '{2'd1, 4'd0,  2'd0, 4'd0, 2'd1, 32'hA5A5_0001, 2'd1, 1'b0},
      '{2'd1, 4'd15, 2'd3, 4'd3, 2'd0, 32'h0,         2'd0, 1'b0},
      '{2'd2, 4'd7,  2'd1, 4'd0, 2'd1, 32'h1234_5678, 2'd1, 1'b0},
      '{2'd2, 4'd8,  2'd2, 4'd0, 2'd0, 32'h5555_5555, 2'd0, 1'b0},
      '{2'd3, 4'd9,  2'd0, 4'd5, 2'd1, 32'hCAFE_0042, 2'd1, 1'b1},
      '{2'd3, 4'd10, 2'd3, 4'd7, 2'd0, 32'hDEAD_0001, 2'd0, 1'b0},
      '{2'd3, 4'd11, 2'd1, 4'd2, 2'd2, 32'hBEEF_0002, 2'd2, 1'b0},
      '{2'd1, 4'd2,  2'd1, 4'd0, 2'd3, 32'h7777_7777, 2'd0, 1'b0}
   };

   task automatic send_coh(input logic [1:0] k, input logic [SET_W-1:0] s,
                           input logic [WAY_W-1:0] w, input logic [NODE_W-1:0] n);
      coh_valid = 1'b1; coh_kind = k; coh_set = s; coh_way = w; coh_node = n;
      while (!coh_ready) @(negedge clk);
      @(negedge clk);
      coh_valid = 1'b0;
   endtask

   task automatic reply(input logic [1:0] st, input logic [DATA_W-1:0] d);
      upr_valid = 1'b1; upr_status = st; upr_data = d;
      @(negedge clk);
      upr_valid = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      send_coh(v.kind, v.set, v.way, v.node);
      lk_set = v.set; lk_way = v.way;
      #1;
      check("R1 pending set after accept", 64'(lk_pending), 64'd1);
      check("R1 up_valid after accept", 64'(up_valid), 64'd1);
      check("R2 forwarded kind/set/way", 64'({up_kind, up_set, up_way}), 64'({v.kind, v.set, v.way}));
      check("R7 ready low while busy", 64'(coh_ready), 64'd0);
      @(negedge clk);
      check("R2 no directory response before reply", 64'(dir_valid), 64'd0);
      reply(v.stat, v.data);
      check("R3 pending cleared", 64'(lk_pending), 64'd0);
      check("R4 dir valid", 64'(dir_valid), 64'd1);
      check("R4 dir code/line", 64'({dir_code, dir_set, dir_way}), 64'({v.dcode, v.set, v.way}));
      check("R4 dir data", 64'(dir_data), (v.stat == 2'd1) ? 64'(v.data) : 64'd0);
      check("R5 requester reply presence", 64'(req_valid), 64'(v.rq));
      if (v.rq) check("R5 requester node/data", 64'({req_node, req_data}), 64'({v.node, v.data}));
      @(negedge clk);
      check("R8 dir response taken once", 64'(dir_valid), 64'd0);
      @(negedge clk);
      check("R7 ready back after drain", 64'(coh_ready), 64'd1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R7 reset coh_ready", 64'(coh_ready), 64'd1);
      check("R2 reset up_valid", 64'(up_valid), 64'd0);
      check("R8 reset dir/req valid", 64'({dir_valid, req_valid}), 64'd0);
      for (int s = 0; s < SETS; s += 5) begin
         lk_set = SET_W'(s); lk_way = WAY_W'(s % WAYS); #1;
         check("R1 reset pending clear", 64'(lk_pending), 64'd0);
      end

      for (int i = 0; i < 10; i++) run_vec(TBL[i]);

      // R2: upward backpressure
      up_ready = 1'b0;
      send_coh(2'd1, 4'd4, 2'd2, 4'd0);
      repeat (3) @(negedge clk);
      check("R2 up_valid held under backpressure", 64'(up_valid), 64'd1);
      check("R2 up fields held", 64'({up_kind, up_set, up_way}), 64'({2'd1, 4'd4, 2'd2}));
      up_ready = 1'b1;
      @(negedge clk);
      check("R2 up_valid drops after take", 64'(up_valid), 64'd0);
      reply(2'd0, 32'h0);
      repeat (2) @(negedge clk);

      // R6: write-back request, negative reply absorbed
      send_coh(2'd2, 4'd6, 2'd3, 4'd0);
      @(negedge clk);
      reply(2'd2, 32'h0);
      lk_set = 4'd6; lk_way = 2'd3; #1;
      check("R6 no dir response on absorbed nack", 64'(dir_valid), 64'd0);
      check("R6 pending stays set", 64'(lk_pending), 64'd1);
      check("R6 still busy", 64'(coh_ready), 64'd0);
      repeat (2) @(negedge clk);
      check("R6 still silent later", 64'(dir_valid), 64'd0);
      reply(2'd1, 32'h0BAD_F00D);
      check("R6 completion dir code/data", 64'({dir_valid, dir_code, dir_data}),
            64'({1'b1, 2'd1, 32'h0BAD_F00D}));
      check("R6 pending cleared on completion", 64'(lk_pending), 64'd0);
      repeat (2) @(negedge clk);

      // R7/R8: directory stalled, requester free, next message waiting
      dir_ready = 1'b0;
      send_coh(2'd3, 4'd12, 2'd0, 4'd9);
      @(negedge clk);
      reply(2'd1, 32'h4242_4242);
      check("R5 both responses present", 64'({dir_valid, req_valid}), 64'd3);
      @(negedge clk);
      check("R8 requester reply taken", 64'(req_valid), 64'd0);
      check("R8 dir held while stalled", 64'({dir_valid, dir_code, dir_data}),
            64'({1'b1, 2'd1, 32'h4242_4242}));
      coh_valid = 1'b1; coh_kind = 2'd0; coh_set = 4'd13; coh_way = 2'd1; coh_node = 4'd0;
      repeat (3) begin
         @(negedge clk);
         check("R7 blocked until dir drained", 64'(coh_ready), 64'd0);
      end
      check("R8 dir still held", 64'({dir_valid, dir_set, dir_way}), 64'({1'b1, 4'd12, 2'd0}));
      dir_ready = 1'b1;
      @(negedge clk);
      check("R8 dir taken", 64'(dir_valid), 64'd0);
      check("R7 ready still low one cycle", 64'(coh_ready), 64'd0);
      @(negedge clk);
      check("R7 ready returns", 64'(coh_ready), 64'd1);
      @(negedge clk);
      coh_valid = 1'b0;
      lk_set = 4'd13; lk_way = 2'd1; #1;
      check("R1 waiting message accepted", 64'({lk_pending, up_valid}), 64'd3);
      @(negedge clk);
      reply(2'd0, 32'h0);
      repeat (2) @(negedge clk);
      check("R7 idle at end", 64'(coh_ready), 64'd1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule